// File: doc/BRIEF.md
# Sectioned Signed Multiply-Accumulator with Output Preload

This block multiplies two signed 16-bit operands and keeps the result in a 35-bit register. The register holds the 32 product bits plus three guard bits. In plain mode each output clock edge loads the sign-extended product. In accumulate mode each edge adds the product to the running total. A synchronous clear forces the total to zero. The operands, the accumulate flag and the clear flag are captured together on the input clock. The result register updates on the output clock one edge later.

The result register is exposed as three sections: a 3-bit guard section, a high 16-bit word and a low 16-bit word. Each section has its own control input, and all sections share one preload control. A section whose control and preload are both low drives its contents. A section whose control and preload are both high takes externally supplied data on the next output edge. Any other combination turns that section's drivers off. Bidirectional pads are split into separate input and output buses, with a drive flag for each section. The binary point is a matter of interpretation only: the same arithmetic serves integer and fractional use.

Top module: `sect_mac`

## Requirements
- R1: While `rst_n` is low at an edge, the result register and the captured operands clear to zero, so every driven section reads zero.
- R2: With accumulate low and clear low, the register loads the signed product `a*b` sign-extended to 35 bits, so bits 34..31 all equal the product sign.
- R3: The product of 0x8000 by 0x8000 is +2^30 (register value 0x0_4000_0000, guard bits 000) with no overflow.
- R4: With accumulate high, the register loads its previous value plus the sign-extended product.
- R5: Accumulation wraps modulo 2^35 without saturation; sixteen additions of 2^30 from zero give 0x4_0000_0000.
- R6: A captured clear sets the whole register to zero on the next output edge, whatever the accumulate flag.
- R7: With preload low and a section control low, the section drive flag is 1 and its output shows that section of the register (guard = bits 34..32, high = bits 31..16, low = bits 15..0).
- R8: With preload high and a section control high, that section's input data is written into that section on the output edge, and sections not loaded take the arithmetic result.
- R9: Any other preload/control combination gives a drive flag of 0 and an output of zero for that section.
- R10: Operands captured on an input edge reach the register on the following output edge, and the output shows the prior result until then.
- R11: A preloaded value acts as the starting total: the next accumulate edge gives the preloaded value plus the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Operand capture clock |
| clk_out | input | 1 | Result register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 16 | Signed operand A |
| b_in | input | 16 | Signed operand B |
| acc_en_in | input | 1 | Accumulate (1) or load product (0), captured with the operands |
| clr_in | input | 1 | Synchronous clear of the total, captured with the operands |
| pre_in | input | 1 | Preload control shared by all sections |
| ext_ctl | input | 1 | Guard section control |
| hi_ctl | input | 1 | High word control |
| lo_ctl | input | 1 | Low word control |
| ext_d | input | 3 | Guard section pad input |
| hi_d | input | 16 | High word pad input |
| lo_d | input | 16 | Low word pad input |
| ext_q | output | 3 | Guard section pad output (zero when not driven) |
| hi_q | output | 16 | High word pad output (zero when not driven) |
| lo_q | output | 16 | Low word pad output (zero when not driven) |
| ext_drv | output | 1 | Guard section driver enable |
| hi_drv | output | 1 | High word driver enable |
| lo_drv | output | 1 | Low word driver enable |

## Verification
A corrupted total does not stay hidden. In accumulate mode it appears on the driven sections at the very next output edge, and every later sum carries the same offset. A fault in the guard bits shows up as a sign extension that does not match the high word, which is visible in plain mode one edge after capture. A wrong section decode shows up at once, without any clock edge, as a drive flag or data value that disagrees with the control inputs. A wrong load mask shows up on the first edge after a preload, when the section is read back.

// File: rtl/sect_mac_pkg.sv
// Package: shared section-mode type and decode for the sectioned MAC.
// Assumes: preload and section control are plain active-high levels.
package sect_mac_pkg;

    typedef enum logic [1:0] {
        SEC_IDLE  = 2'd0,
        SEC_DRIVE = 2'd1,
        SEC_LOAD  = 2'd2
    } sec_mode_e;

    // Map preload and section control to a section mode.
    function automatic sec_mode_e sec_decode(input logic pre, input logic ctl);
        if (!pre && !ctl) begin
            return SEC_DRIVE;
        end else if (pre && ctl) begin
            return SEC_LOAD;
        end else begin
            return SEC_IDLE;
        end
    endfunction

endpackage

// File: rtl/sect_mac_operand_stage.sv
// Operand stage: registers both operands plus the accumulate and clear
// flags on the input clock. Assumes a synchronous active-low reset.
module sect_mac_operand_stage #(
    parameter int OP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] a_i,
    input  logic [OP_W-1:0] b_i,
    input  logic            acc_i,
    input  logic            clr_i,
    output logic [OP_W-1:0] a_q,
    output logic [OP_W-1:0] b_q,
    output logic            acc_q,
    output logic            clr_q
);

    // Capture one operand set per input edge; reset clears all of it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            acc_q <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            a_q   <= a_i;
            b_q   <= b_i;
            acc_q <= acc_i;
            clr_q <= clr_i;
        end
    end

endmodule

// File: rtl/sect_mac_product.sv
// Product unit: signed OP_W x OP_W multiply, sign-extended to the full
// accumulator width. Purely combinational; assumes ACC_W > 2*OP_W.
module sect_mac_product #(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 3,
    localparam int PROD_W = 2 * OP_W,
    localparam int ACC_W  = PROD_W + GUARD_W
) (
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    output logic [ACC_W-1:0] prod_o
);

    logic signed [PROD_W-1:0] prod_s;

    // Full-width signed product, then replicate its sign into the guard bits.
    always_comb begin
        prod_s = $signed(a_i) * $signed(b_i);
        prod_o = {{GUARD_W{prod_s[PROD_W-1]}}, prod_s};
    end

endmodule

// File: rtl/sect_mac_accum.sv
// Accumulator register: chooses clear / accumulate / load-product, then
// overrides any sections being preloaded with pad data. Sections are
// low word [OP_W-1:0], high word [2*OP_W-1:OP_W], guard bits above.
// Assumes load_i = {guard, high, low} and a synchronous active-low reset.
module sect_mac_accum #(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 3,
    localparam int PROD_W = 2 * OP_W,
    localparam int ACC_W  = PROD_W + GUARD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] prod_i,
    input  logic             acc_en_i,
    input  logic             clr_i,
    input  logic [2:0]       load_i,
    input  logic [ACC_W-1:0] pre_d_i,
    output logic [ACC_W-1:0] acc_o
);

    logic [ACC_W-1:0] arith_nxt;
    logic [ACC_W-1:0] load_mask;
    logic [ACC_W-1:0] acc_nxt;

    // Spread the per-section load flags over the bits each section owns.
    generate
        for (genvar i = 0; i < ACC_W; i++) begin : g_mask
            if (i < OP_W) begin : g_lo
                assign load_mask[i] = load_i[0];
            end else if (i < PROD_W) begin : g_hi
                assign load_mask[i] = load_i[1];
            end else begin : g_ext
                assign load_mask[i] = load_i[2];
            end
        end
    endgenerate

    // Arithmetic next value: clear wins, else accumulate, else plain product.
    always_comb begin
        if (clr_i) begin
            arith_nxt = '0;
        end else if (acc_en_i) begin
            arith_nxt = acc_o + prod_i;
        end else begin
            arith_nxt = prod_i;
        end
    end

    // Merge preload data into the selected sections.
    always_comb begin
        acc_nxt = (arith_nxt & ~load_mask) | (pre_d_i & load_mask);
    end

    // Result register on the output clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else begin
            acc_o <= acc_nxt;
        end
    end

    AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i == 3'b000 && !acc_en_i && !clr_i)
        |=> (acc_o[ACC_W-1:PROD_W-1] == '0 || acc_o[ACC_W-1:PROD_W-1] == '1)); // R2

    AST_ACCUM_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i == 3'b000 && acc_en_i && !clr_i)
        |=> (acc_o == $past(acc_o) + $past(prod_i))); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i == 3'b000 && clr_i) |=> (acc_o == '0)); // R6

    AST_PRELOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        load_i[0] |=> (acc_o[OP_W-1:0] == $past(pre_d_i[OP_W-1:0]))); // R8

    AST_PRELOAD_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        load_i[2] |=> (acc_o[ACC_W-1:PROD_W] == $past(pre_d_i[ACC_W-1:PROD_W]))); // R8

endmodule

// File: rtl/sect_mac_section.sv
// Section port: decodes preload and section control into drive / load /
// off, and gates the register bits onto the pad output when driving.
// Assumes undriven pads read as zero on the split output bus.
module sect_mac_section #(
    parameter int W = 16
) (
    input  logic         pre_i,
    input  logic         ctl_i,
    input  logic [W-1:0] reg_i,
    output logic [W-1:0] q_o,
    output logic         drv_o,
    output logic         load_o
);

    sect_mac_pkg::sec_mode_e mode;

    // Decode the mode and drive the pad only in the drive mode.
    always_comb begin
        mode   = sect_mac_pkg::sec_decode(pre_i, ctl_i);
        drv_o  = (mode == sect_mac_pkg::SEC_DRIVE);
        load_o = (mode == sect_mac_pkg::SEC_LOAD);
        q_o    = drv_o ? reg_i : '0;
    end

endmodule

// File: rtl/sect_mac.sv
// Top: sectioned signed multiply-accumulator. Operands are captured on
// clk_in, the 35-bit total updates on clk_out, and three output sections
// (guard, high, low) can each drive, be preloaded, or be switched off.
// Assumes synchronous active-low reset sampled in both clock domains.
module sect_mac #(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 3,
    localparam int PROD_W = 2 * OP_W,
    localparam int ACC_W  = PROD_W + GUARD_W
) (
    input  logic               clk_in,
    input  logic               clk_out,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    a_in,
    input  logic [OP_W-1:0]    b_in,
    input  logic               acc_en_in,
    input  logic               clr_in,
    input  logic               pre_in,
    input  logic               ext_ctl,
    input  logic               hi_ctl,
    input  logic               lo_ctl,
    input  logic [GUARD_W-1:0] ext_d,
    input  logic [OP_W-1:0]    hi_d,
    input  logic [OP_W-1:0]    lo_d,
    output logic [GUARD_W-1:0] ext_q,
    output logic [OP_W-1:0]    hi_q,
    output logic [OP_W-1:0]    lo_q,
    output logic               ext_drv,
    output logic               hi_drv,
    output logic               lo_drv
);

    localparam logic [OP_W-1:0]  OP_MIN  = {1'b1, {(OP_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] MIN_SQR = {{(ACC_W-1){1'b0}}, 1'b1} << (PROD_W - 2);

    logic [OP_W-1:0]  a_q;
    logic [OP_W-1:0]  b_q;
    logic             acc_q;
    logic             clr_q;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] acc;
    logic             ext_load;
    logic             hi_load;
    logic             lo_load;

    sect_mac_operand_stage #(.OP_W(OP_W)) u_ops (
        .clk   (clk_in),
        .rst_n (rst_n),
        .a_i   (a_in),
        .b_i   (b_in),
        .acc_i (acc_en_in),
        .clr_i (clr_in),
        .a_q   (a_q),
        .b_q   (b_q),
        .acc_q (acc_q),
        .clr_q (clr_q)
    );

    sect_mac_product #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_prod (
        .a_i    (a_q),
        .b_i    (b_q),
        .prod_o (prod)
    );

    sect_mac_accum #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_acc (
        .clk      (clk_out),
        .rst_n    (rst_n),
        .prod_i   (prod),
        .acc_en_i (acc_q),
        .clr_i    (clr_q),
        .load_i   ({ext_load, hi_load, lo_load}),
        .pre_d_i  ({ext_d, hi_d, lo_d}),
        .acc_o    (acc)
    );

    sect_mac_section #(.W(GUARD_W)) u_sec_ext (
        .pre_i  (pre_in),
        .ctl_i  (ext_ctl),
        .reg_i  (acc[ACC_W-1:PROD_W]),
        .q_o    (ext_q),
        .drv_o  (ext_drv),
        .load_o (ext_load)
    );

    sect_mac_section #(.W(OP_W)) u_sec_hi (
        .pre_i  (pre_in),
        .ctl_i  (hi_ctl),
        .reg_i  (acc[PROD_W-1:OP_W]),
        .q_o    (hi_q),
        .drv_o  (hi_drv),
        .load_o (hi_load)
    );

    sect_mac_section #(.W(OP_W)) u_sec_lo (
        .pre_i  (pre_in),
        .ctl_i  (lo_ctl),
        .reg_i  (acc[OP_W-1:0]),
        .q_o    (lo_q),
        .drv_o  (lo_drv),
        .load_o (lo_load)
    );

    AST_MIN_SQUARE_POSITIVE: assert property (@(posedge clk_out) disable iff (!rst_n)
        (a_q == OP_MIN && b_q == OP_MIN) |-> (prod == MIN_SQR)); // R3

    AST_PRELOAD_MUTES_PADS: assert property (@(posedge clk_out) disable iff (!rst_n)
        pre_in |-> !(ext_drv || hi_drv || lo_drv)); // R9

    AST_CAPTURE_LATENCY: assert property (@(posedge clk_out) disable iff (!rst_n)
        (!pre_in && !acc_q && !clr_q) |=> (acc == $past(prod))); // R10

endmodule

// File: tb/sect_mac_tb_top.sv
// Bench: sweeps corner operand pairs, accumulation and wrap, every
// preload/control combination, and preload-then-accumulate, against a
// cycle model built from the requirements.
module sect_mac_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n;
    logic signed [15:0] a_in, b_in;
    logic               acc_en_in, clr_in, pre_in;
    logic               ext_ctl, hi_ctl, lo_ctl;
    logic [2:0]         ext_d;
    logic [15:0]        hi_d, lo_d;
    logic [2:0]         ext_q;
    logic [15:0]        hi_q, lo_q;
    logic               ext_drv, hi_drv, lo_drv;

    sect_mac dut_i (
        .clk_in(clk), .clk_out(clk), .rst_n(rst_n),
        .a_in(a_in), .b_in(b_in), .acc_en_in(acc_en_in), .clr_in(clr_in),
        .pre_in(pre_in), .ext_ctl(ext_ctl), .hi_ctl(hi_ctl), .lo_ctl(lo_ctl),
        .ext_d(ext_d), .hi_d(hi_d), .lo_d(lo_d),
        .ext_q(ext_q), .hi_q(hi_q), .lo_q(lo_q),
        .ext_drv(ext_drv), .hi_drv(hi_drv), .lo_drv(lo_drv)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic signed [15:0] m_a, m_b;
    logic               m_acc, m_clr;
    logic [34:0]        m_reg;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of one shared clock edge, using inputs as held at the edge.
    task automatic model_edge();
        logic signed [31:0] p;
        logic [34:0]        nx;
        p = m_a * m_b;
        if (!rst_n) begin
            m_reg = '0; m_a = '0; m_b = '0; m_acc = 1'b0; m_clr = 1'b0;
        end else begin
            if (m_clr)      nx = '0;
            else if (m_acc) nx = m_reg + {{3{p[31]}}, p};
            else            nx = {{3{p[31]}}, p};
            if (pre_in && ext_ctl) nx[34:32] = ext_d;
            if (pre_in && hi_ctl)  nx[31:16] = hi_d;
            if (pre_in && lo_ctl)  nx[15:0]  = lo_d;
            m_reg = nx;
            m_a = a_in; m_b = b_in; m_acc = acc_en_in; m_clr = clr_in;
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    // Compare drive flags and pad data against the model.
    task automatic check_ports(input string req);
        logic de, dh, dl;
        logic [37:0] exp;
        de = !pre_in && !ext_ctl;
        dh = !pre_in && !hi_ctl;
        dl = !pre_in && !lo_ctl;
        exp = {de, dh, dl,
               de ? m_reg[34:32] : 3'b0,
               dh ? m_reg[31:16] : 16'b0,
               dl ? m_reg[15:0]  : 16'b0};
        chk(req, {26'b0, ext_drv, hi_drv, lo_drv, ext_q, hi_q, lo_q}, {26'b0, exp});
    endtask

    function automatic logic [34:0] pads();
        return {ext_q, hi_q, lo_q};
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic signed [15:0] vals [8];
        logic [34:0]        sum;
        vals = '{16'sh0000, 16'sh0001, -16'sh0001, 16'sh0002,
                 16'sh7FFF, 16'sh8000, 16'sh8001, 16'sh1234};

        rst_n = 1'b0; a_in = 16'sh1111; b_in = 16'sh2222;
        acc_en_in = 1'b1; clr_in = 1'b0; pre_in = 1'b0;
        ext_ctl = 1'b0; hi_ctl = 1'b0; lo_ctl = 1'b0;
        ext_d = '0; hi_d = '0; lo_d = '0;
        m_a = '0; m_b = '0; m_acc = 1'b0; m_clr = 1'b0; m_reg = '0;
        repeat (3) cycle();
        // R1: reset state at the pads
        chk("R1", {29'b0, pads()}, 64'd0);
        check_ports("R1");
        rst_n = 1'b1;
        acc_en_in = 1'b0;

        // R2: plain products over all corner pairs
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                longint e;
                a_in = vals[i]; b_in = vals[j];
                cycle();
                cycle();
                e = longint'(vals[i]) * longint'(vals[j]);
                chk("R2", {29'b0, pads()}, {29'b0, 35'(e)});
                check_ports("R2");
            end
        end

        // R3: most negative squared is +2^30
        a_in = 16'sh8000; b_in = 16'sh8000;
        cycle(); cycle();
        chk("R3", {29'b0, pads()}, {29'b0, 35'h0_4000_0000});
        chk("R3 guard", {61'b0, ext_q}, 64'd0);

        // R10: one capture edge, then one register edge
        a_in = 16'sd3; b_in = 16'sd5;
        cycle();
        chk("R10 hold", {29'b0, pads()}, {29'b0, 35'h0_4000_0000});
        cycle();
        chk("R10 update", {29'b0, pads()}, 64'd15);

        // R6: clear zeroes the total even with accumulate requested
        clr_in = 1'b1; acc_en_in = 1'b1;
        cycle();
        clr_in = 1'b0;
        a_in = 16'sd0; b_in = 16'sd0;
        cycle();
        chk("R6", {29'b0, pads()}, 64'd0);

        // R4: running sum over mixed-sign pairs
        sum = '0;
        for (int i = 0; i < 8; i++) begin
            logic signed [31:0] p;
            a_in = vals[i]; b_in = vals[(i * 3 + 1) % 8];
            cycle();
            p = vals[i] * vals[(i * 3 + 1) % 8];
            check_ports("R4");
            sum = sum + {{3{p[31]}}, p};
        end
        cycle();
        chk("R4 total", {29'b0, pads()}, {29'b0, sum});

        // R5: wrap after sixteen additions of 2^30
        clr_in = 1'b1;
        cycle();
        clr_in = 1'b0; a_in = 16'sh8000; b_in = 16'sh8000;
        cycle();
        for (int k = 1; k <= 20; k++) begin
            cycle();
            check_ports("R5");
            if (k == 16) chk("R5 wrap", {29'b0, pads()}, {29'b0, 35'h4_0000_0000});
        end

        // R7/R8/R9: every preload and control combination
        acc_en_in = 1'b0; a_in = 16'sh0101; b_in = 16'sh0003;
        ext_d = 3'b101; hi_d = 16'hA5C3; lo_d = 16'h3C5A;
        cycle();
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 8; c++) begin
                pre_in = p[0];
                {ext_ctl, hi_ctl, lo_ctl} = c[2:0];
                #1;
                if (p == 0 && c == 0) check_ports("R7");
                else                  check_ports("R9");
                cycle();
                pre_in = 1'b0; {ext_ctl, hi_ctl, lo_ctl} = 3'b000;
                #1;
                check_ports("R8");
            end
        end

        // R11: preload becomes the starting total for accumulation
        a_in = 16'sd2; b_in = -16'sd7; acc_en_in = 1'b1;
        cycle();
        pre_in = 1'b1; {ext_ctl, hi_ctl, lo_ctl} = 3'b111;
        ext_d = 3'b000; hi_d = 16'h0001; lo_d = 16'h0000;
        cycle();
        pre_in = 1'b0; {ext_ctl, hi_ctl, lo_ctl} = 3'b000;
        #1;
        chk("R8 full", {29'b0, pads()}, 64'd65536);
        cycle();
        chk("R11", {29'b0, pads()}, 64'd65522);
        check_ports("R11");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule